// File: doc/BRIEF.md
# Asynchronous Serial Communications Interface

This block is a full-duplex UART that carries characters on one serial output line and one serial input line. Both lines use nonreturn-to-zero coding and rest at the mark level (logic 1). A host CPU drives the block through four byte-wide registers with simple write and read strobes. Those registers are data, control, status and a baud divisor. An internal generator divides the system clock to make a 16x oversampling tick. Each bit time is 16 ticks, so a bit lasts 16 × (divisor + 1) clock cycles.

The transmitter has one holding register in front of a shift register. It sends one start bit, then 8 or 9 data bits with the least significant bit first, then one stop bit. On request it sends a whole character of marks (idle) or a whole character of spaces (break). The receiver synchronizes the input and votes three samples near the middle of each bit. It reports noise, overrun and framing errors in separate status bits. Software can put the receiver to sleep, and a full idle character on the line wakes it again. Three interrupt lines are provided: one for transmit, one for receive and one for idle line.

Register map. Address 0 is the data register. A write fills the transmit holding register. A read returns the received byte and clears the receive flags. Address 1 is control: bit0 transmit enable, bit1 receive enable, bit2 nine-bit mode, bit3 sleep, bit4 queue idle, bit5 queue break, bit6 ninth transmit bit. Address 2 is status and is read-only: bit0 holding empty, bit1 transmit complete, bit2 receive full, bit3 idle seen, bit4 overrun, bit5 noise, bit6 framing error, bit7 ninth received bit. Address 3 is the baud divisor, and its reset value is 3.

Top module: `sci_uart`

## Requirements
- R1: After reset, `ser_out` is 1, all three interrupt lines are 0, and status reads 0x03 (holding empty and transmit complete set, every other bit clear).
- R2: With divisor D, each transmitted bit after the start bit stays on the line for exactly 16 × (D + 1) clock cycles.
- R3: An 8-bit character goes out as a start bit 0, then data bits LSB first, then a stop bit 1; the line sits at 1 between characters.
- R4: In nine-bit mode (control bit2 set), control bit6 is sent as a ninth data bit just before the stop bit. A received ninth bit appears in status bit7.
- R5: Setting control bit5 queues a break of all zeros, and control bit4 queues an idle character of all ones. Each is one full character long. The bit reads back as 1 until its character starts, then clears by itself. Transmit complete stays 0 while such a character is pending or being sent.
- R6: Each received bit takes the majority of three mid-bit samples. A disagreement among them still delivers the correct data and sets status bit5 (noise).
- R7: A low pulse shorter than half a bit is rejected as a false start: no character is received, and the next valid character is received correctly.
- R8: A low stop bit sets status bit6 (framing error), and the data is still delivered.
- R9: A character that completes while receive full is set sets status bit4 (overrun) and is discarded; the data register keeps the earlier byte.
- R10: While control bit3 (sleep) is set, completed characters are not stored. After one full character time of idle line, the hardware clears bit3 without raising the idle flag, and reception resumes.
- R11: One full character time of marks after a stored character sets status bit3 and raises `irq_idle`.
- R12: `irq_tx` equals transmit enable AND holding empty, and `irq_rx` follows receive full. While transmit is disabled, a written byte waits in the holding register.
- R13: Reading the data register clears receive full, overrun, noise, framing error and idle-seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered one cycle after `rd_en` |
| ser_in | input | 1 | Serial receive line, rests at 1 |
| ser_out | output | 1 | Serial transmit line, rests at 1 |
| irq_tx | output | 1 | Transmit interrupt request |
| irq_rx | output | 1 | Receive interrupt request |
| irq_idle | output | 1 | Idle-line interrupt request |

## Verification
The bench injects a glitch exactly one sample wide in the middle of a data bit. A receiver that sampled only once would return a corrupted byte, and one without voting would leave the noise flag clear. A sub-half-bit low pulse checks that the receiver does not lock onto a false start and shift garbage. Two back-to-back characters check that the receiver keeps the first byte, instead of overwriting it or losing the overrun flag. The sleep sequence checks that no character is stored while asleep, that an idle line wakes the receiver, and that waking does not also raise the idle interrupt. The queued break and idle characters check that the request bits clear only once the character starts, and that transmit complete stays low throughout.

// File: rtl/sci_pkg.sv
package sci_pkg;
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_BAUD = 2'd3;

  localparam int C_TXEN  = 0;
  localparam int C_RXEN  = 1;
  localparam int C_LEN9  = 2;
  localparam int C_SLEEP = 3;
  localparam int C_IDLE  = 4;
  localparam int C_BRK   = 5;
  localparam int C_TB8   = 6;

  typedef enum logic [1:0] {RX_HUNT, RX_DATA, RX_STOP} rx_state_t;

  typedef struct packed {
    logic rx_b8;
    logic ferr;
    logic noise;
    logic ovr;
    logic idle;
    logic full;
    logic tdone;
    logic tempty;
  } stat_t;
endpackage

// File: rtl/sci_baud.sv
module sci_baud #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);
endmodule

// File: rtl/sci_tx.sv
module sci_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          tx_en,
  input  logic          len9,
  input  logic          req_data,
  input  logic [DATA_W:0] data9,
  input  logic          req_idle,
  input  logic          req_brk,
  output logic          ack_data,
  output logic          ack_idle,
  output logic          ack_brk,
  output logic          busy,
  output logic          ser_out
);
  localparam int FW = DATA_W + 3;
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(FW + 1);

  logic [FW-1:0] sh, frame;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] left, nbits;
  logic          start;

  always_comb begin
    nbits    = len9 ? BW'(FW) : BW'(FW - 1);
    ack_brk  = 1'b0;
    ack_idle = 1'b0;
    ack_data = 1'b0;
    frame    = '1;
    if (!busy && tx_en) begin
      if (req_brk) begin
        ack_brk = 1'b1;
        frame   = '0;
      end else if (req_idle) begin
        ack_idle = 1'b1;
      end else if (req_data) begin
        ack_data = 1'b1;
        frame    = len9 ? {1'b1, data9, 1'b0} : {2'b11, data9[DATA_W-1:0], 1'b0};
      end
    end
    start = ack_brk | ack_idle | ack_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      ser_out <= 1'b1;
      sh      <= '1;
      tcnt    <= '0;
      left    <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      sh      <= frame;
      ser_out <= frame[0];
      tcnt    <= '0;
      left    <= nbits;
    end else if (busy) begin
      if (tick) begin
        if (tcnt == CW'(OSR - 1)) begin
          tcnt <= '0;
          if (left == BW'(1)) begin
            busy <= 1'b0;
          end else begin
            sh      <= {1'b1, sh[FW-1:1]};
            ser_out <= sh[1];
            left    <= left - 1'b1;
          end
        end else begin
          tcnt <= tcnt + 1'b1;
        end
      end
    end else begin
      ser_out <= 1'b1;
    end
  end

  // R3
  line_rest_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy)) |-> ser_out);
endmodule

// File: rtl/sci_rx.sv
module sci_rx
  import sci_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            rx_en,
  input  logic            len9,
  input  logic            line,
  input  logic            idle_restart,
  output logic            done,
  output logic [DATA_W:0] rdata9,
  output logic            noise,
  output logic            ferr,
  output logic            idle_evt
);
  localparam int CW       = $clog2(OSR);
  localparam int S1       = OSR / 2;
  localparam int S0       = S1 - 1;
  localparam int S2       = S1 + 1;
  localparam int FMAX     = DATA_W + 3;
  localparam int IDLE_MAX = FMAX * OSR;
  localparam int IW       = $clog2(IDLE_MAX + 1);
  localparam int BW       = $clog2(DATA_W + 2);

  rx_state_t       state;
  logic [CW-1:0]   cnt;
  logic [BW-1:0]   bitn, nd;
  logic [1:0]      smp;
  logic [DATA_W:0] sh;
  logic            nacc, maj, dis;
  logic [IW-1:0]   icnt, thr;

  always_comb begin
    maj = (smp[0] & smp[1]) | (smp[0] & line) | (smp[1] & line);
    dis = (smp[0] != smp[1]) | (smp[1] != line);
    nd  = len9 ? BW'(DATA_W + 1) : BW'(DATA_W);
    thr = len9 ? IW'(IDLE_MAX) : IW'(IDLE_MAX - OSR);
  end

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      state  <= RX_HUNT;
      cnt    <= '0;
      bitn   <= '0;
      smp    <= '0;
      sh     <= '0;
      nacc   <= 1'b0;
      rdata9 <= '0;
      noise  <= 1'b0;
      ferr   <= 1'b0;
    end else if (!rx_en) begin
      state <= RX_HUNT;
    end else if (tick) begin
      if (state == RX_HUNT) begin
        if (!line) begin
          state <= RX_DATA;
          cnt   <= '0;
          bitn  <= '0;
          nacc  <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt == CW'(S0)) smp[0] <= line;
        if (cnt == CW'(S1)) smp[1] <= line;
        if (cnt == CW'(S2)) begin
          if (state == RX_STOP) begin
            done   <= 1'b1;
            ferr   <= !maj;
            noise  <= nacc | dis;
            rdata9 <= len9 ? sh : {1'b0, sh[DATA_W:1]};
            state  <= RX_HUNT;
          end else if (bitn == '0) begin
            if (maj) state <= RX_HUNT;
            else nacc <= nacc | dis;
          end else begin
            sh   <= {maj, sh[DATA_W:1]};
            nacc <= nacc | dis;
          end
        end
        if (cnt == CW'(OSR - 1) && state == RX_DATA) begin
          if (bitn == nd) state <= RX_STOP;
          bitn <= bitn + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    idle_evt <= 1'b0;
    if (rst || idle_restart || !line || !rx_en) begin
      icnt <= '0;
    end else if (tick && icnt != thr) begin
      icnt <= icnt + 1'b1;
      if (icnt == thr - 1'b1) idle_evt <= 1'b1;
    end
  end
endmodule

// File: rtl/sci_uart.sv
module sci_uart
  import sci_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int DIV_W     = 8,
  parameter int OSR       = 16,
  parameter int RESET_DIV = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata,
  input  logic             ser_in,
  output logic             ser_out,
  output logic             irq_tx,
  output logic             irq_rx,
  output logic             irq_idle
);
  localparam int DATA_W = REG_W;

  logic             tx_en, rx_en, len9, sleep, pend_idle, pend_brk, tx_b8;
  logic [DIV_W-1:0] div;
  logic [DATA_W:0]  hold, rx_data, rx_d9;
  logic             hold_full, rx_full, ovr, nf, fe, idle_flag, armed;
  logic [1:0]       sync;
  logic             tick, ack_data, ack_idle, ack_brk, tx_busy;
  logic             rx_done, rx_noise, rx_ferr, idle_evt;
  logic             wr_data, wr_ctrl, wr_baud, rd_data, restart;
  stat_t            stat;

  assign wr_data = wr_en && addr == A_DATA;
  assign wr_ctrl = wr_en && addr == A_CTRL;
  assign wr_baud = wr_en && addr == A_BAUD;
  assign rd_data = rd_en && addr == A_DATA;
  assign restart = wr_ctrl && wdata[C_SLEEP];

  sci_baud #(.DIV_W(DIV_W)) u_baud (.clk(clk), .rst(rst), .div(div), .tick(tick));

  sci_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .tx_en(tx_en), .len9(len9),
    .req_data(hold_full), .data9(hold), .req_idle(pend_idle), .req_brk(pend_brk),
    .ack_data(ack_data), .ack_idle(ack_idle), .ack_brk(ack_brk),
    .busy(tx_busy), .ser_out(ser_out));

  sci_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rx_en(rx_en), .len9(len9),
    .line(sync[1]), .idle_restart(restart), .done(rx_done), .rdata9(rx_d9),
    .noise(rx_noise), .ferr(rx_ferr), .idle_evt(idle_evt));

  always_comb begin
    stat.rx_b8  = rx_data[DATA_W];
    stat.ferr   = fe;
    stat.noise  = nf;
    stat.ovr    = ovr;
    stat.idle   = idle_flag;
    stat.full   = rx_full;
    stat.tdone  = !hold_full && !tx_busy && !pend_idle && !pend_brk;
    stat.tempty = !hold_full;
  end

  assign irq_tx   = tx_en & !hold_full;
  assign irq_rx   = rx_full;
  assign irq_idle = idle_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      {tx_en, rx_en, len9, sleep, pend_idle, pend_brk, tx_b8} <= '0;
      div       <= DIV_W'(RESET_DIV);
      hold      <= '0;
      hold_full <= 1'b0;
      rx_data   <= '0;
      {rx_full, ovr, nf, fe, idle_flag, armed} <= '0;
      sync      <= 2'b11;
      rdata     <= '0;
    end else begin
      sync <= {sync[0], ser_in};
      if (idle_evt && sleep) sleep <= 1'b0;
      if (ack_idle) pend_idle <= 1'b0;
      if (ack_brk) pend_brk <= 1'b0;
      if (wr_ctrl) begin
        tx_en <= wdata[C_TXEN];
        rx_en <= wdata[C_RXEN];
        len9  <= wdata[C_LEN9];
        sleep <= wdata[C_SLEEP];
        tx_b8 <= wdata[C_TB8];
        if (wdata[C_IDLE]) pend_idle <= 1'b1;
        if (wdata[C_BRK]) pend_brk <= 1'b1;
      end
      if (wr_baud) div <= DIV_W'(wdata);
      if (wr_data) begin
        hold      <= {tx_b8, wdata};
        hold_full <= 1'b1;
      end else if (ack_data) begin
        hold_full <= 1'b0;
      end
      if (rd_data) {rx_full, ovr, nf, fe, idle_flag} <= '0;
      if (rx_done && !sleep) begin
        if (rx_full && !rd_data) begin
          ovr <= 1'b1;
        end else begin
          rx_data <= rx_d9;
          rx_full <= 1'b1;
          nf      <= rx_noise;
          fe      <= rx_ferr;
          armed   <= 1'b1;
        end
      end
      if (idle_evt && !sleep && armed) begin
        idle_flag <= 1'b1;
        armed     <= 1'b0;
      end
      if (rd_en) begin
        case (addr)
          A_DATA:  rdata <= rx_data[DATA_W-1:0];
          A_CTRL:  rdata <= REG_W'({tx_b8, pend_brk, pend_idle, sleep, len9, rx_en, tx_en});
          A_STAT:  rdata <= REG_W'(stat);
          default: rdata <= REG_W'(div);
        endcase
      end
    end
  end

  // R9
  ovr_full_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovr) |-> $past(rx_full));
  // R13
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_full) |-> $past(rd_en && addr == A_DATA));
  // R10
  sleep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_full) |-> !$past(sleep));
  // R5
  brk_start_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_brk) |-> tx_busy);
endmodule

// File: tb/sci_uart_bench.sv
module sci_uart_bench;
  localparam int BITC = 64;

  logic       clk = 1'b0;
  logic       rst, wr_en, rd_en, ser_in;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       ser_out, irq_tx, irq_rx, irq_idle;
  int         n_chk = 0;
  int         n_fail = 0;

  // {len9, ninth bit, data}
  localparam logic [9:0] VECS [0:5] = '{10'h0A5, 10'h000, 10'h0FF, 10'h03C, 10'h35A, 10'h2C3};

  sci_uart u_sci_uart (.clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .ser_in(ser_in), .ser_out(ser_out),
    .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_idle(irq_idle));

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  function automatic logic [10:0] mkf(input logic [7:0] d, input logic l9, input logic b8, input logic stp);
    if (l9) return {stp, b8, d, 1'b0};
    return {1'b1, stp, d, 1'b0};
  endfunction

  task automatic send_line(input logic [10:0] f, input int nb, input int gb);
    for (int i = 0; i < nb; i++) begin
      @(negedge clk); ser_in = f[i];
      if (i == gb) begin
        repeat (32) @(negedge clk); ser_in = ~f[i];
        repeat (4) @(negedge clk); ser_in = f[i];
        repeat (BITC - 37) @(negedge clk);
      end else begin
        repeat (BITC - 1) @(negedge clk);
      end
    end
    @(negedge clk); ser_in = 1'b1;
  endtask

  task automatic get_tx(input string req, input int nb, output logic [10:0] f);
    int w = 0;
    f = '1;
    while (ser_out !== 1'b0 && w < 4000) begin @(negedge clk); w++; end
    if (w >= 4000) chk(req, 32'd0, 32'd1);
    repeat (32) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      f[i] = ser_out;
      repeat (BITC) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run hung (all requirements), actual running expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0]  v;
    logic [10:0] f;
    int          n;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; ser_in = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 ser_out", ser_out, 1);
    chk("R1 irqs", {irq_tx, irq_rx, irq_idle}, 0);
    rd(2'd2, v); chk("R1 status", v, 8'h03);

    // R12 held byte while transmit disabled
    wr(2'd1, 8'h02);
    chk("R12 irq_tx off", irq_tx, 0);
    wr(2'd0, 8'h55);
    repeat (200) @(negedge clk);
    rd(2'd2, v); chk("R12 holding full", v[0], 0);
    chk("R12 line quiet", ser_out, 1);
    wr(2'd1, 8'h03);
    get_tx("R12", 10, f); chk("R12 R3 frame 55", f, mkf(8'h55, 0, 0, 1));
    chk("R12 irq_tx on", irq_tx, 1);

    // table: transmit and receive each pattern
    for (int k = 0; k < 6; k++) begin
      logic l9, b8;
      logic [7:0] d;
      l9 = VECS[k][9]; b8 = VECS[k][8]; d = VECS[k][7:0];
      n = l9 ? 11 : 10;
      wr(2'd1, {1'b0, b8, 3'b000, l9, 2'b11});
      wr(2'd0, d);
      get_tx("R3", n, f); chk(l9 ? "R4 tx frame" : "R3 tx frame", f, mkf(d, l9, b8, 1));
      send_line(mkf(d, l9, b8, 1), n, -1);
      repeat (4) @(negedge clk);
      chk("R12 irq_rx", irq_rx, 1);
      rd(2'd2, v); chk("R4 rx ninth bit", v[7], l9 ? b8 : 1'b0);
      rd(2'd0, v); chk("R3 rx data", v, d);
      rd(2'd2, v); chk("R13 full cleared", v[2], 0);
    end
    wr(2'd1, 8'h03);
    repeat (BITC * 12) @(negedge clk);

    // R2 bit period on bit1 of 0x05
    wr(2'd0, 8'h05);
    while (ser_out !== 1'b0) @(negedge clk);
    while (ser_out !== 1'b1) @(negedge clk);
    while (ser_out !== 1'b0) @(negedge clk);
    n = 0;
    while (ser_out === 1'b0 && n < 500) begin n++; @(negedge clk); end
    chk("R2 bit length", n, BITC);
    repeat (BITC * 10) @(negedge clk);

    // R6 noise glitch on data bit2
    send_line(mkf(8'hA5, 0, 0, 1), 10, 3);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R6 noise flag", v[5], 1);
    rd(2'd0, v); chk("R6 voted data", v, 8'hA5);
    rd(2'd2, v); chk("R13 noise cleared", v[5], 0);

    // R7 false start
    @(negedge clk); ser_in = 1'b0;
    repeat (12) @(negedge clk); ser_in = 1'b1;
    repeat (BITC * 12) @(negedge clk);
    rd(2'd2, v); chk("R7 no char", v[2], 0);
    send_line(mkf(8'h3C, 0, 0, 1), 10, -1);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R7 recovered", v, 8'h3C);

    // R8 framing error
    send_line(mkf(8'h81, 0, 0, 0), 10, -1);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R8 framing flag", v[6], 1);
    rd(2'd0, v); chk("R8 data", v, 8'h81);

    // R9 overrun
    repeat (BITC * 2) @(negedge clk);
    send_line(mkf(8'h11, 0, 0, 1), 10, -1);
    send_line(mkf(8'h22, 0, 0, 1), 10, -1);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R9 overrun flag", v[4], 1);
    rd(2'd0, v); chk("R9 kept first", v, 8'h11);
    repeat (BITC * 12) @(negedge clk);
    rd(2'd0, v);

    // R11 idle flag
    send_line(mkf(8'h44, 0, 0, 1), 10, -1);
    rd(2'd0, v);
    chk("R11 idle low early", irq_idle, 0);
    repeat (BITC * 12) @(negedge clk);
    chk("R11 irq_idle", irq_idle, 1);
    rd(2'd2, v); chk("R11 idle status", v[3], 1);
    rd(2'd0, v); chk("R13 idle cleared", irq_idle, 0);

    // R10 sleep and wake
    wr(2'd1, 8'h0B);
    send_line(mkf(8'h77, 0, 0, 1), 10, -1);
    repeat (4) @(negedge clk);
    rd(2'd2, v); chk("R10 not stored", v[2], 0);
    rd(2'd1, v); chk("R10 still asleep", v[3], 1);
    repeat (BITC * 12) @(negedge clk);
    rd(2'd1, v); chk("R10 woken", v[3], 0);
    chk("R10 no idle irq", irq_idle, 0);
    send_line(mkf(8'h66, 0, 0, 1), 10, -1);
    repeat (4) @(negedge clk);
    rd(2'd0, v); chk("R10 resumed", v, 8'h66);

    // R5 break then idle
    wr(2'd1, 8'h23);
    rd(2'd2, v); chk("R5 tdone low brk", v[1], 0);
    get_tx("R5", 10, f); chk("R5 break frame", f, 11'h400);
    rd(2'd1, v); chk("R5 brk cleared", v[5], 0);
    repeat (BITC) @(negedge clk);
    wr(2'd1, 8'h13);
    repeat (4) @(negedge clk);
    rd(2'd1, v); chk("R5 idle cleared", v[4], 0);
    rd(2'd2, v); chk("R5 tdone low idle", v[1], 0);
    n = 0;
    repeat (BITC * 9) begin @(negedge clk); if (ser_out !== 1'b1) n++; end
    chk("R5 idle marks", n, 0);
    repeat (BITC * 2) @(negedge clk);
    rd(2'd2, v); chk("R5 tdone after", v[1], 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule